// File: doc/BRIEF.md
# Guest Address Window Guard

This block sits in front of guest memory and checks every load and store before it reaches the array. A request carries a 64-bit effective address, an access width of 1, 2, 4 or 8 bytes, and a write flag. The guard keeps only the low 32 bits of the address, so the whole 64-bit space maps onto copies of one 4 GiB window. It then classifies the access against a fixed layout of that window:

- A low guard band that is never mapped.
- A code window that can be read but not written.
- A data area that runs to the top of the window and can be read and written.

One cycle after the request it returns the folded 32-bit offset together with a verdict. The verdict is either a grant, or a fault with a reason. The reason says whether the access touched the guard band or tried to write the code window.

Alignment is never a reason to refuse an access. An access whose bytes cross a region boundary is judged on its first and last byte offsets. The last offset is computed modulo 2^32, so an access that runs off the top of the window wraps onto offset 0. The layout is set by parameters: the code base and the code window size, with the data base derived from them. With the default values, the guard band is below 0x0040_0000, code runs from there up to 0x1000_0000 (252 MiB), and data lies above.

Top module: `gmc_guard`

## Requirements
- R1: `rsp_offset` equals bits [31:0] of the request address. The upper 32 address bits have no effect on the offset or on the verdict.
- R2: A request sampled with `req_valid` high produces `rsp_valid` high at the next clock edge. A cycle with `req_valid` low produces `rsp_valid`, `rsp_grant` and `rsp_fault` all low one edge later.
- R3: `rsp_grant` and `rsp_fault` are never high together. While `rsp_valid` is high, exactly one of them is high.
- R4: If the first or last byte offset lies below the code base (0x0040_0000), the access faults with `rsp_reason` = 2'b01. This applies to both reads and writes, and takes priority over every other outcome.
- R5: A write that has no guard-band end, but has its first or last byte offset in the code window [0x0040_0000, 0x1000_0000), faults with `rsp_reason` = 2'b10. On a grant, `rsp_reason` is 2'b00.
- R6: A read whose two end offsets both lie in the code window or the data area is granted.
- R7: A write whose two end offsets both lie in the data area [0x1000_0000, 2^32) is granted.
- R8: `req_size` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Any start offset is legal for any width, and no access faults because it is misaligned.
- R9: The last byte offset is the first offset plus the width minus one, modulo 2^32. An access that wraps past 0xFFFF_FFFF therefore ends in the guard band and faults under R4.
- R10: While `rst` is high, `rsp_valid`, `rsp_grant` and `rsp_fault` are 0 and `rsp_reason` is 2'b00 at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Effective address of the access |
| req_size | input | 2 | Access width code (1, 2, 4 or 8 bytes) |
| req_write | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_offset | output | 32 | Folded offset within the 4 GiB window |
| rsp_grant | output | 1 | Access permitted |
| rsp_fault | output | 1 | Access refused |
| rsp_reason | output | 2 | 00 none, 01 guard band, 10 write to code |

## Verification
The bench builds the guard with its default layout: a code base of 0x0040_0000 and a code window of 0x0FC0_0000, which puts the data base at 0x1000_0000. Those values are small enough that random offsets steered near the three edges (0x0040_0000, 0x1000_0000 and the 2^32 wrap) produce accesses that cross a boundary for every width. Directed cases then pin the crossing from guard band to code, a write crossing from code into data, and a wrap from the top of the window onto offset 0. Random upper address bits show that the fold ignores them.

// File: rtl/gmc_pkg.sv
package gmc_pkg;

  typedef enum logic [1:0] {
    RG_NULL = 2'd0,
    RG_CODE = 2'd1,
    RG_DATA = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    WHY_NONE    = 2'b00,
    WHY_NULL    = 2'b01,
    WHY_CODE_WR = 2'b10
  } why_e;

  typedef struct packed {
    logic grant;
    logic fault;
    why_e why;
  } verdict_t;

endpackage

// File: rtl/gmc_span.sv
module gmc_span #(
  parameter int OFF_W  = 32,
  parameter int SIZE_W = 2
) (
  input  logic [OFF_W-1:0]  first_off,
  input  logic [SIZE_W-1:0] size_code,
  output logic [OFF_W-1:0]  last_off
);
  logic [OFF_W-1:0] extra;

  always_comb begin
    extra    = (OFF_W'(1) << size_code) - OFF_W'(1);
    last_off = first_off + extra;
  end
endmodule

// File: rtl/gmc_region.sv
module gmc_region
  import gmc_pkg::*;
#(
  parameter int               OFF_W     = 32,
  parameter logic [OFF_W-1:0] CODE_BASE = 32'h0040_0000,
  parameter logic [OFF_W-1:0] DATA_BASE = 32'h1000_0000
) (
  input  logic [OFF_W-1:0] off,
  output region_e          rg
);
  always_comb begin
    if (off < CODE_BASE)      rg = RG_NULL;
    else if (off < DATA_BASE) rg = RG_CODE;
    else                      rg = RG_DATA;
  end
endmodule

// File: rtl/gmc_verdict.sv
module gmc_verdict
  import gmc_pkg::*;
#(
  parameter int ENDS = 2
) (
  input  region_e [ENDS-1:0] ends_rg,
  input  logic               is_write,
  output verdict_t           verdict
);
  logic hit_null;
  logic hit_code;

  always_comb begin
    hit_null = 1'b0;
    hit_code = 1'b0;
    for (int i = 0; i < ENDS; i++) begin
      if (ends_rg[i] == RG_NULL) hit_null = 1'b1;
      if (ends_rg[i] == RG_CODE) hit_code = 1'b1;
    end
    if (hit_null) begin
      verdict = '{grant: 1'b0, fault: 1'b1, why: WHY_NULL};
    end else if (is_write && hit_code) begin
      verdict = '{grant: 1'b0, fault: 1'b1, why: WHY_CODE_WR};
    end else begin
      verdict = '{grant: 1'b1, fault: 1'b0, why: WHY_NONE};
    end
  end
endmodule

// File: rtl/gmc_guard.sv
module gmc_guard
  import gmc_pkg::*;
#(
  parameter int               ADDR_W    = 64,
  parameter int               OFF_W     = 32,
  parameter int               SIZE_W    = 2,
  parameter logic [OFF_W-1:0] CODE_BASE = 32'h0040_0000,
  parameter logic [OFF_W-1:0] CODE_SIZE = 32'h0FC0_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [OFF_W-1:0]  rsp_offset,
  output logic              rsp_grant,
  output logic              rsp_fault,
  output logic [1:0]        rsp_reason
);
  localparam logic [OFF_W-1:0] DATA_BASE = CODE_BASE + CODE_SIZE;
  localparam int               N_ENDS    = 2;

  logic [OFF_W-1:0]               first_off;
  logic [OFF_W-1:0]               last_off;
  logic [N_ENDS-1:0][OFF_W-1:0]   end_off;
  region_e [N_ENDS-1:0]           end_rg;
  verdict_t                       verdict;
  logic                           unused_hi;

  assign first_off = req_addr[OFF_W-1:0];
  assign unused_hi = ^req_addr[ADDR_W-1:OFF_W];

  gmc_span #(.OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_span (
    .first_off (first_off),
    .size_code (req_size),
    .last_off  (last_off)
  );

  assign end_off[0] = first_off;
  assign end_off[1] = last_off;

  for (genvar g = 0; g < N_ENDS; g++) begin : g_end
    gmc_region #(
      .OFF_W     (OFF_W),
      .CODE_BASE (CODE_BASE),
      .DATA_BASE (DATA_BASE)
    ) u_rg (
      .off (end_off[g]),
      .rg  (end_rg[g])
    );
  end

  gmc_verdict #(.ENDS(N_ENDS)) u_verdict (
    .ends_rg  (end_rg),
    .is_write (req_write),
    .verdict  (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_offset <= '0;
      rsp_grant  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_reason <= WHY_NONE;
    end else begin
      rsp_valid  <= req_valid;
      rsp_offset <= first_off;
      rsp_grant  <= req_valid & verdict.grant;
      rsp_fault  <= req_valid & verdict.fault;
      rsp_reason <= req_valid ? verdict.why : WHY_NONE;
    end
  end
endmodule

// File: rtl/gmc_guard_chk.sv
module gmc_guard_chk #(
  parameter int               OFF_W     = 32,
  parameter logic [OFF_W-1:0] CODE_BASE = 32'h0040_0000
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [OFF_W-1:0] req_lo,
  input logic             req_write,
  input logic             rsp_valid,
  input logic [OFF_W-1:0] rsp_offset,
  input logic             rsp_grant,
  input logic             rsp_fault,
  input logic [1:0]       rsp_reason
);
  // R3
  grant_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_grant && rsp_fault));

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid && (rsp_grant ^ rsp_fault));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_grant && !rsp_fault);

  // R1
  offset_fold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_offset == $past(req_lo));

  // R4
  null_start_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && (req_lo < CODE_BASE) |=> rsp_fault && rsp_reason == 2'b01);

  // R6
  mapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && (req_lo >= CODE_BASE) && (req_lo <= ~OFF_W'(7))
    |=> rsp_grant);

  // R5
  reason_match_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_grant == (rsp_reason == 2'b00)));
endmodule

bind gmc_guard gmc_guard_chk #(.OFF_W(OFF_W), .CODE_BASE(CODE_BASE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_lo     (req_addr[OFF_W-1:0]),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_offset (rsp_offset),
  .rsp_grant  (rsp_grant),
  .rsp_fault  (rsp_fault),
  .rsp_reason (rsp_reason)
);

// File: tb/gmc_guard_tb.sv
module gmc_guard_tb;
  localparam logic [31:0] CB = 32'h0040_0000;
  localparam logic [31:0] DB = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [63:0] req_addr;
  logic [1:0]  req_size;
  logic        req_write;
  logic        rsp_valid;
  logic [31:0] rsp_offset;
  logic        rsp_grant;
  logic        rsp_fault;
  logic [1:0]  rsp_reason;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  gmc_guard u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_offset(rsp_offset), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
    .rsp_reason(rsp_reason)
  );

  function automatic logic [1:0] cls(input logic [31:0] o);
    if (o < CB) return 2'd0;
    if (o < DB) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [1:0] expect_reason(input logic [63:0] a,
                                                input logic [1:0] sz,
                                                input logic wr);
    logic [31:0] f, l;
    f = a[31:0];
    l = f + ((32'd1 << sz) - 32'd1);
    if (cls(f) == 2'd0 || cls(l) == 2'd0) return 2'b01;
    if (wr && (cls(f) == 2'd1 || cls(l) == 2'd1)) return 2'b10;
    return 2'b00;
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input string tag, input logic [63:0] a,
                        input logic [1:0] sz, input logic wr);
    logic [1:0] er;
    er = expect_reason(a, sz, wr);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    @(negedge clk);
    chk({tag, " R1 offset"}, {4'h0, rsp_offset}, {4'h0, a[31:0]});
    chk({tag, " R2/R3 verdict"}, {32'h0, rsp_valid, rsp_grant, rsp_fault, 1'b0},
        {32'h0, 1'b1, er == 2'b00, er != 2'b00, 1'b0});
    chk({tag, " reason"}, {34'h0, rsp_reason}, {34'h0, er});
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b1; req_addr = 64'h1000_0000; req_size = 2'd0; req_write = 1'b0;
    repeat (2) @(negedge clk);
    // R10: reset holds outputs low even with a request present
    chk("R10 reset", {32'h0, rsp_valid, rsp_grant, rsp_fault, 1'b0}, 36'h0);
    chk("R10 reason", {34'h0, rsp_reason}, 36'h0);
    rst = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    // R2: idle cycle
    chk("R2 idle", {32'h0, rsp_valid, rsp_grant, rsp_fault, 1'b0}, 36'h0);

    access("R4 null read",         64'h0000_0000_0000_0010, 2'd2, 1'b0);
    access("R4 null write",        64'h0000_0000_003F_FFFF, 2'd0, 1'b1);
    access("R4 null-to-code read", 64'h0000_0000_003F_FFFE, 2'd2, 1'b0);
    access("R6 code read",         64'h0000_0000_0040_0000, 2'd3, 1'b0);
    access("R5 code write",        64'h0000_0000_0080_0001, 2'd1, 1'b1);
    access("R5 code-to-data write",64'h0000_0000_0FFF_FFFE, 2'd2, 1'b1);
    access("R6 code-to-data read", 64'h0000_0000_0FFF_FFFD, 2'd3, 1'b0);
    access("R7 data write",        64'h0000_0000_1000_0000, 2'd3, 1'b1);
    access("R8 misaligned write",  64'h0000_0000_2000_0003, 2'd3, 1'b1);
    access("R8 misaligned half",   64'h0000_0000_1234_5677, 2'd1, 1'b0);
    access("R9 top no wrap",       64'h0000_0000_FFFF_FFF8, 2'd3, 1'b1);
    access("R9 wrap to null",      64'h0000_0000_FFFF_FFFE, 2'd2, 1'b0);
    access("R1 upper bits data",   64'hDEAD_BEEF_1000_0000, 2'd3, 1'b1);
    access("R1 upper bits null",   64'hFFFF_FFFF_0000_0000, 2'd0, 1'b0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R2 idle after burst", {32'h0, rsp_valid, rsp_grant, rsp_fault, 1'b0}, 36'h0);

    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a;
      logic [31:0] base;
      case ($urandom % 4)
        0: base = CB;
        1: base = DB;
        2: base = 32'h0;
        default: base = $urandom;
      endcase
      a = {$urandom, base + 32'($urandom % 16) - 32'd8};
      access("R3 random", a, 2'($urandom), 1'($urandom));
    end
    req_valid = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule